// File: doc/BRIEF.md
# SPI Host FIFO and Interrupt Frontend

This block is the register-facing half of an SPI host controller. Software talks to it through a simple single-cycle register port: it writes transmit words into a 16-entry transmit FIFO and reads received words out of a 16-entry receive FIFO. The serial shift engine, which is not part of this block, sits on the other side. It pops transmit words, pushes received words and pulses a completion strobe for each direction when a transfer finishes.

A status word packs the fill level of each FIFO together with a transmit-full bit and a receive-empty bit. FIFO events are latched into a FIFO flag register. These events are the threshold crossings, transmit empty, receive full, a dropped transmit write and a read from an empty receive FIFO. The two completion strobes are latched into a separate transfer flag register. Software clears a flag by writing one to its bit. Each flag register has its own enable mask. The single interrupt output is raised whenever any flag in either group is set while its enable bit is also set.

Top module: `spi_fe_top`

## Requirements
- R1: Each FIFO holds 16 words of 32 bits and returns them in the order they were written. The status register (address 2) reports the transmit level in bits 12:8, transmit-full (level 16) in bit 4, the receive level in bits 28:24 and receive-empty (level 0) in bit 20. All other status bits read as 0.
- R2: A write to the transmit data register (address 3) while the transmit FIFO is full drops the word, leaves the level at 16 and sets transmit-overflow (FIFO flag bit 17).
- R3: A read of the receive data register (address 4) while the receive FIFO is empty returns 0 and sets receive-underrun (FIFO flag bit 16).
- R4: In the control register (address 0), writing bit 2 empties the transmit FIFO and writing bit 3 empties the receive FIFO. Bit 0 is a stored run bit that drives `run_o` and reads back in bit 0.
- R5: The config register (address 1) bits 1:0 select the threshold: code 0 is 8 words, code 1 is 4 words, code 2 is 1 word and code 3 behaves like code 0. Transmit-threshold (FIFO flag bit 5) is set while the transmit level is at or below the threshold. Receive-threshold (FIFO flag bit 4) is set while the receive level is at or above it.
- R6: Receive-full (FIFO flag bit 8) is set while the receive level is 16. Transmit-empty (FIFO flag bit 9) is set while the transmit level is 0. Both flags stay latched after their condition goes away.
- R7: A pulse on `core_rx_done` sets receive-complete (transfer flag bit 0) and a pulse on `core_tx_done` sets transmit-complete (transfer flag bit 1). The transfer flag register is at address 7.
- R8: Writing a flag register clears every bit written as one and leaves bits written as zero alone. A flag whose set condition is true in the same cycle as its clear stays set.
- R9: The FIFO enable mask is at address 6 and the transfer enable mask at address 8; both read back as written. `irq_o` is high exactly when some flag in either group is set with its enable bit set.
- R10: The engine side pops the transmit head with `core_tx_pop` (shown on `core_tx_data` while `core_tx_valid` is high) and pushes with `core_rx_push`. A pop of an empty transmit FIFO and a push to a full receive FIFO have no effect on the levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 4) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| run_o | output | 1 | Stored run bit |
| irq_o | output | 1 | Interrupt request |
| core_tx_pop | input | 1 | Engine takes the transmit head word |
| core_tx_data | output | 32 | Transmit head word |
| core_tx_valid | output | 1 | Transmit FIFO not empty |
| core_rx_push | input | 1 | Engine delivers a received word |
| core_rx_data | input | 32 | Received word |
| core_tx_done | input | 1 | Transmit-complete pulse |
| core_rx_done | input | 1 | Receive-complete pulse |

## Verification
The hardest situation to reach is a flag clear that lands in the same cycle as a new set event, because the write strobe and the engine strobe must meet on one clock edge. The bench drives the write to the transfer flag register and the completion pulse on the same negative edge, so both are seen at the same rising edge. Threshold boundaries are reached in a directed way: the bench fills each FIFO to one word short of each threshold code, clears the flags, then moves the level by one word. A long seeded random mix of writes, reads, pops and pushes then drives both FIFOs into full and empty repeatedly against a queue model.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    typedef enum logic [3:0] {
        ADDR_CTRL = 4'd0,
        ADDR_CFG  = 4'd1,
        ADDR_STAT = 4'd2,
        ADDR_TXD  = 4'd3,
        ADDR_RXD  = 4'd4,
        ADDR_FFLG = 4'd5,
        ADDR_FEN  = 4'd6,
        ADDR_XFLG = 4'd7,
        ADDR_XEN  = 4'd8
    } reg_addr_e;

    // FIFO flag bit positions in the register word
    localparam int unsigned FB_RXTHR  = 4;
    localparam int unsigned FB_TXTHR  = 5;
    localparam int unsigned FB_RXFULL = 8;
    localparam int unsigned FB_TXEMP  = 9;
    localparam int unsigned FB_RXUND  = 16;
    localparam int unsigned FB_TXOVF  = 17;

    // internal FIFO flag index order
    localparam int unsigned FI_RXTHR  = 0;
    localparam int unsigned FI_TXTHR  = 1;
    localparam int unsigned FI_RXFULL = 2;
    localparam int unsigned FI_TXEMP  = 3;
    localparam int unsigned FI_RXUND  = 4;
    localparam int unsigned FI_TXOVF  = 5;
    localparam int unsigned N_FFLG    = 6;
    localparam int unsigned N_XFLG    = 2;

    function automatic logic [7:0] thr_words(input logic [1:0] code);
        case (code)
            2'd1:    thr_words = 8'd4;
            2'd2:    thr_words = 8'd1;
            default: thr_words = 8'd8;
        endcase
    endfunction

endpackage

// File: rtl/spi_fe_fifo.sv
module spi_fe_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr_i,
    input  logic                           push_i,
    input  logic [WIDTH-1:0]               push_data_i,
    input  logic                           pop_i,
    output logic [WIDTH-1:0]               pop_data_o,
    output logic [$clog2(DEPTH+1)-1:0]     level_o,
    output logic                           full_o,
    output logic                           empty_o
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned LW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PW-1:0]               wr;
        logic [PW-1:0]               rd;
        logic [LW-1:0]               cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push_i && (st_q.cnt != LW'(DEPTH));
        do_pop  = pop_i && (st_q.cnt != '0);
        if (clr_i) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = push_data_i;
                st_d.wr           = st_q.wr + PW'(1);
            end
            if (do_pop) begin
                st_d.rd = st_q.rd + PW'(1);
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + LW'(1);
                2'b01:   st_d.cnt = st_q.cnt - LW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pop_data_o = st_q.mem[st_q.rd];
    assign level_o    = st_q.cnt;
    assign full_o     = (st_q.cnt == LW'(DEPTH));
    assign empty_o    = (st_q.cnt == '0);

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LW'(DEPTH));
    assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.cnt == '0));
    assert_no_push_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !clr_i && !pop_i) |=> full_o);
endmodule

// File: rtl/spi_fe_flags.sv
module spi_fe_flags #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_wr_i,
    input  logic [N-1:0] clr_mask_i,
    input  logic         en_wr_i,
    input  logic [N-1:0] en_val_i,
    output logic [N-1:0] flags_o,
    output logic [N-1:0] en_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] flags;
        logic [N-1:0] en;
    } flg_st_t;

    flg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_wr_i) st_d.flags = st_q.flags & ~clr_mask_i;
        st_d.flags = st_d.flags | set_i;
        if (en_wr_i) st_d.en = en_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign en_o    = st_q.en;
    assign irq_o   = |(st_q.flags & st_q.en);

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_o[i]);
        assert_rise_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags_o[i]) |-> $past(set_i[i]));
        assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr_i && clr_mask_i[i] && !set_i[i]) |=> !flags_o[i]);
    end
endmodule

// File: rtl/spi_fe_top.sv
module spi_fe_top
    import spi_fe_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        run_o,
    output logic        irq_o,
    input  logic        core_tx_pop,
    output logic [31:0] core_tx_data,
    output logic        core_tx_valid,
    input  logic        core_rx_push,
    input  logic [31:0] core_rx_data,
    input  logic        core_tx_done,
    input  logic        core_rx_done
);
    localparam int unsigned LW = $clog2(DEPTH+1);

    typedef struct packed {
        logic       run;
        logic [1:0] thr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic          wr_ctrl, tx_clr, rx_clr, tx_push, rx_pop;
    logic [31:0]   rx_head;
    logic [LW-1:0] tx_lvl, rx_lvl;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]    thr8;
    logic [N_FFLG-1:0] f_set, f_mask, f_flags, f_en;
    logic [N_XFLG-1:0] x_flags, x_en;
    logic          f_irq, x_irq;
    logic [31:0]   f_word, f_en_word, stat_word;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign tx_clr  = wr_ctrl && reg_wdata[2];
    assign rx_clr  = wr_ctrl && reg_wdata[3];
    assign tx_push = reg_wr && (reg_addr == ADDR_TXD);
    assign rx_pop  = reg_rd && (reg_addr == ADDR_RXD);

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl) cfg_d.run = reg_wdata[0];
        if (reg_wr && (reg_addr == ADDR_CFG)) cfg_d.thr = reg_wdata[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    spi_fe_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .clr_i(tx_clr),
        .push_i(tx_push), .push_data_i(reg_wdata),
        .pop_i(core_tx_pop), .pop_data_o(core_tx_data),
        .level_o(tx_lvl), .full_o(tx_full), .empty_o(tx_empty)
    );

    spi_fe_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .clr_i(rx_clr),
        .push_i(core_rx_push), .push_data_i(core_rx_data),
        .pop_i(rx_pop), .pop_data_o(rx_head),
        .level_o(rx_lvl), .full_o(rx_full), .empty_o(rx_empty)
    );

    assign core_tx_valid = !tx_empty;
    assign thr8          = thr_words(cfg_q.thr);

    always_comb begin
        f_set            = '0;
        f_set[FI_RXTHR]  = (8'(rx_lvl) >= thr8);
        f_set[FI_TXTHR]  = (8'(tx_lvl) <= thr8);
        f_set[FI_RXFULL] = rx_full;
        f_set[FI_TXEMP]  = tx_empty;
        f_set[FI_RXUND]  = rx_pop && rx_empty;
        f_set[FI_TXOVF]  = tx_push && tx_full;
    end

    // map between register bit positions and the compact flag vector
    always_comb begin
        f_mask            = '0;
        f_mask[FI_RXTHR]  = reg_wdata[FB_RXTHR];
        f_mask[FI_TXTHR]  = reg_wdata[FB_TXTHR];
        f_mask[FI_RXFULL] = reg_wdata[FB_RXFULL];
        f_mask[FI_TXEMP]  = reg_wdata[FB_TXEMP];
        f_mask[FI_RXUND]  = reg_wdata[FB_RXUND];
        f_mask[FI_TXOVF]  = reg_wdata[FB_TXOVF];
        f_word            = '0;
        f_word[FB_RXTHR]  = f_flags[FI_RXTHR];
        f_word[FB_TXTHR]  = f_flags[FI_TXTHR];
        f_word[FB_RXFULL] = f_flags[FI_RXFULL];
        f_word[FB_TXEMP]  = f_flags[FI_TXEMP];
        f_word[FB_RXUND]  = f_flags[FI_RXUND];
        f_word[FB_TXOVF]  = f_flags[FI_TXOVF];
        f_en_word            = '0;
        f_en_word[FB_RXTHR]  = f_en[FI_RXTHR];
        f_en_word[FB_TXTHR]  = f_en[FI_TXTHR];
        f_en_word[FB_RXFULL] = f_en[FI_RXFULL];
        f_en_word[FB_TXEMP]  = f_en[FI_TXEMP];
        f_en_word[FB_RXUND]  = f_en[FI_RXUND];
        f_en_word[FB_TXOVF]  = f_en[FI_TXOVF];
    end

    spi_fe_flags #(.N(N_FFLG)) u_fflg (
        .clk(clk), .rst_n(rst_n), .set_i(f_set),
        .clr_wr_i(reg_wr && (reg_addr == ADDR_FFLG)), .clr_mask_i(f_mask),
        .en_wr_i(reg_wr && (reg_addr == ADDR_FEN)), .en_val_i(f_mask),
        .flags_o(f_flags), .en_o(f_en), .irq_o(f_irq)
    );

    spi_fe_flags #(.N(N_XFLG)) u_xflg (
        .clk(clk), .rst_n(rst_n), .set_i({core_tx_done, core_rx_done}),
        .clr_wr_i(reg_wr && (reg_addr == ADDR_XFLG)), .clr_mask_i(reg_wdata[1:0]),
        .en_wr_i(reg_wr && (reg_addr == ADDR_XEN)), .en_val_i(reg_wdata[1:0]),
        .flags_o(x_flags), .en_o(x_en), .irq_o(x_irq)
    );

    assign irq_o = f_irq || x_irq;
    assign run_o = cfg_q.run;

    always_comb begin
        stat_word        = '0;
        stat_word[4]     = tx_full;
        stat_word[15:8]  = 8'(tx_lvl);
        stat_word[20]    = rx_empty;
        stat_word[31:24] = 8'(rx_lvl);
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: reg_rdata[0]   = cfg_q.run;
            ADDR_CFG:  reg_rdata[1:0] = cfg_q.thr;
            ADDR_STAT: reg_rdata      = stat_word;
            ADDR_RXD:  reg_rdata      = rx_empty ? '0 : rx_head;
            ADDR_FFLG: reg_rdata      = f_word;
            ADDR_FEN:  reg_rdata      = f_en_word;
            ADDR_XFLG: reg_rdata[1:0] = x_flags;
            ADDR_XEN:  reg_rdata[1:0] = x_en;
            default:   reg_rdata      = '0;
        endcase
    end

    assert_tx_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full) |=> f_flags[FI_TXOVF]);
    assert_underrun_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |-> (reg_rdata == '0));
    assert_run_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (run_o == $past(reg_wdata[0])));
    assert_done_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        core_rx_done |=> x_flags[0]);
endmodule

// File: tb/spi_fe_top_tb_top.sv
module spi_fe_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        run_o, irq_o;
    logic        core_tx_pop = 0, core_rx_push = 0, core_tx_done = 0, core_rx_done = 0;
    logic [31:0] core_tx_data, core_rx_data = 0;
    logic        core_tx_valid;

    int n_chk = 0, n_bad = 0;
    bit [31:0] txq[$], rxq[$];
    bit m_ovf = 0, m_und = 0;

    always #2 clk = ~clk;

    spi_fe_top dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat(input int txl, input int rxl);
        logic [31:0] s = '0;
        s[15:8]  = 8'(txl);
        s[4]     = (txl == 16);
        s[31:24] = 8'(rxl);
        s[20]    = (rxl == 0);
        return s;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic rx_push(input logic [31:0] d);
        @(negedge clk); core_rx_push = 1; core_rx_data = d;
        @(negedge clk); core_rx_push = 0;
    endtask

    task automatic tx_pop(output logic [31:0] d);
        @(negedge clk); d = core_tx_data; core_tx_pop = 1;
        @(negedge clk); core_tx_pop = 0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, g;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1;
        settle();
        // reset state
        rd(4'd2, v); check("R1 reset status", v, exp_stat(0, 0));
        check("R9 reset irq", {31'b0, irq_o}, 0);
        rd(4'd5, v); check("R6 R5 reset tx-empty and tx-threshold", v, 32'h0000_0220);
        // R9 enable tx-empty
        wr(4'd6, 32'h0000_0200);
        check("R9 irq on enabled flag", {31'b0, irq_o}, 1);
        rd(4'd6, v); check("R9 enable readback", v, 32'h0000_0200);
        wr(4'd6, 32'h0);
        check("R9 irq masked", {31'b0, irq_o}, 0);
        // R8 set wins while condition true
        wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd5, v); check("R8 clear while condition holds", v, 32'h0000_0220);
        // fill tx
        for (int i = 0; i < 16; i++) wr(4'd3, 32'hA000_0000 + i);
        rd(4'd2, v); check("R1 tx full status", v, exp_stat(16, 0));
        wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd5, v); check("R8 all-ones clears", v, 32'h0);
        wr(4'd3, 32'hDEAD_BEEF);
        rd(4'd5, v); check("R2 overflow flag", v, 32'h0002_0000);
        rd(4'd2, v); check("R2 level stays 16", v, exp_stat(16, 0));
        wr(4'd5, 32'h0000_0001);
        rd(4'd5, v); check("R8 zero bits untouched", v, 32'h0002_0000);
        for (int i = 0; i < 16; i++) begin
            tx_pop(g); check("R1 R10 tx order", g, 32'hA000_0000 + i);
        end
        check("R10 tx valid low", {31'b0, core_tx_valid}, 0);
        tx_pop(g);
        rd(4'd2, v); check("R10 pop empty tx ignored", v, exp_stat(0, 0));
        rd(4'd5, v); check("R6 tx-empty latched", v[9], 1);
        // R4 fifo reset and run
        for (int i = 0; i < 5; i++) wr(4'd3, i);
        wr(4'd0, 32'h4);
        rd(4'd2, v); check("R4 tx reset", v, exp_stat(0, 0));
        wr(4'd0, 32'h1);
        rd(4'd0, v); check("R4 run readback", v, 1);
        check("R4 run output", {31'b0, run_o}, 1);
        // R3 underrun
        wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd4, v); check("R3 empty read zero", v, 0);
        rd(4'd5, v); check("R3 underrun flag", v[16], 1);
        // rx fill beyond full
        for (int i = 0; i < 20; i++) rx_push(32'hB000_0000 + i);
        rd(4'd2, v); check("R10 rx push to full dropped", v, exp_stat(0, 16));
        rd(4'd5, v); check("R6 rx-full flag", v[8], 1);
        for (int i = 0; i < 16; i++) begin
            rd(4'd4, v); check("R1 rx order", v, 32'hB000_0000 + i);
        end
        wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd5, v); check("R6 rx-full cleared after drain", v[8], 0);
        // R5 thresholds
        for (int c = 0; c < 4; c++) begin
            int t;
            t = (c == 1) ? 4 : (c == 2) ? 1 : 8;
            wr(4'd1, c);
            wr(4'd0, 32'hC);
            for (int i = 0; i < t - 1; i++) rx_push(i);
            for (int i = 0; i < t + 1; i++) wr(4'd3, i);
            wr(4'd5, 32'hFFFF_FFFF);
            rd(4'd5, v);
            check("R5 rx below threshold", v[4], 0);
            check("R5 tx above threshold", v[5], 0);
            rx_push(32'h55);
            tx_pop(g);
            settle();
            rd(4'd5, v);
            check("R5 rx at threshold", v[4], 1);
            check("R5 tx at threshold", v[5], 1);
        end
        // R7 transfer flags
        wr(4'd7, 32'h3);
        @(negedge clk); core_rx_done = 1; @(negedge clk); core_rx_done = 0;
        rd(4'd7, v); check("R7 rx complete", v, 1);
        @(negedge clk); core_tx_done = 1; @(negedge clk); core_tx_done = 0;
        rd(4'd7, v); check("R7 tx complete", v, 3);
        wr(4'd6, 0); wr(4'd8, 32'h2);
        check("R9 irq from transfer group", {31'b0, irq_o}, 1);
        wr(4'd7, 32'h2);
        rd(4'd7, v); check("R8 transfer clear", v, 1);
        check("R9 irq drops", {31'b0, irq_o}, 0);
        @(negedge clk); reg_wr = 1; reg_addr = 4'd7; reg_wdata = 32'h2; core_tx_done = 1;
        @(negedge clk); reg_wr = 0; core_tx_done = 0;
        rd(4'd7, v); check("R8 same-cycle set wins", v, 3);
        check("R9 irq after set-wins", {31'b0, irq_o}, 1);
        // random phase
        wr(4'd0, 32'hC); wr(4'd5, 32'hFFFF_FFFF); wr(4'd8, 0);
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom_range(0, 3));
            d = $urandom;
            case (op)
                0: begin
                    if (txq.size() < 16) txq.push_back(d); else m_ovf = 1;
                    wr(4'd3, d);
                end
                1: begin
                    tx_pop(g);
                    if (txq.size() > 0) check("R10 random tx data", g, txq.pop_front());
                end
                2: begin
                    if (rxq.size() < 16) rxq.push_back(d);
                    rx_push(d);
                end
                default: begin
                    rd(4'd4, v);
                    if (rxq.size() > 0) check("R1 random rx data", v, rxq.pop_front());
                    else begin m_und = 1; check("R3 random empty read", v, 0); end
                end
            endcase
            rd(4'd2, v); check("R1 random status", v, exp_stat(txq.size(), rxq.size()));
        end
        rd(4'd5, v);
        check("R2 random overflow sticky", v[17], m_ovf);
        check("R3 random underrun sticky", v[16], m_und);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule